// File: doc/BRIEF.md
# Triggered Multi-Channel DMA Controller

This block moves words between memory locations on behalf of a CPU that shares the same memory bus. It has three channels. Software programs each channel through a write-only register port with four values: a source address, a destination address, a transfer count and a control word. The control word picks the channel's transfer style, its address stepping and which of eight request lines starts it. A request is a rising edge on the chosen line. A global input can veto requests, for example while software reprograms the channels or while an urgent event is being handled.

Every transfer is one bus read from the source followed by one bus write of the same word to the destination. While the controller drives the bus it raises a hold output that stalls the CPU. The channel's style decides how much work one request starts:

- One word per request.
- The whole remaining count back-to-back.
- The whole count, with one bus cycle handed back to the CPU after every four transfers.

Each style can be marked repeating. A repeating channel reloads its programmed addresses and count when the count runs out, and stays armed. A non-repeating channel disarms itself. Each channel pulses its own interrupt bit when its count runs out. When more than one channel is waiting, a software-set priority list decides the order.

Top module: `tdma_ctrl`

## Requirements
- R1: After reset, cpu_hold_o, mem_re_o, mem_we_o and irq_o are all low and every channel is disarmed, so edges on any request line start no bus cycle. The priority list resets to channel 0 first, then 1, then 2.
- R2: The register address is {channel[1:0], field[1:0]} with field 0 = control, 1 = source, 2 = destination, 3 = count. A channel responds only to a rising edge on the request line whose number is held in control bits [12:10]. Bit [0] arms the channel.
- R3: A rising edge seen while trig_block_i is high is discarded. It does not start a transfer later when trig_block_i falls.
- R4: Waiting channels are served one after another in the order of the priority register: address {2'b11, 2'b00}, slot bits [1:0] first, [3:2] second, [5:4] last, each slot holding a channel number.
- R5: Each transfer is a cycle with mem_re_o high at the source address, then a cycle with mem_we_o high at the destination address carrying the word read. cpu_hold_o is high in both cycles, and mem_re_o and mem_we_o are never high together.
- R6: Control bits [5:4] (source) and [8:7] (destination) select 0 = fixed, 1 = increment, 2 = decrement. Bits [6] (source) and [9] (destination) select a step of 2 instead of 1. The address steps after every transfer.
- R7: Mode code 0 in control bits [2:1] (single) moves one word per request. A non-repeating single channel disarms itself once the count reaches zero, and later requests move nothing.
- R8: A channel whose count is zero moves no data when its request line fires.
- R9: Mode code 1 (block) moves the whole count on one request, with cpu_hold_o high without a break for two cycles per word. It then disarms unless it repeats.
- R10: Mode code 2 (burst) moves the whole count on one request. After every fourth transfer that is not the last, cpu_hold_o drops for exactly one cycle before the next read.
- R11: irq_o[n] pulses high for one cycle after channel n's count runs out, in every mode, and at no other time.
- R12: With control bit [3] set (repeat), running out of count reloads the last programmed source, destination and count, and the channel stays armed for the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address {channel, field}; channel 3 is global |
| reg_wdata_i | input | 16 | Register write data |
| dma_req_i | input | 8 | Request lines, rising-edge sensitive |
| trig_block_i | input | 1 | Discards requests while high |
| cpu_hold_o | output | 1 | CPU stalled, controller owns the bus |
| mem_re_o | output | 1 | Bus read cycle |
| mem_we_o | output | 1 | Bus write cycle |
| mem_addr_o | output | 16 | Bus address |
| mem_wdata_o | output | 16 | Bus write data |
| mem_rdata_i | input | 16 | Bus read data, valid in the read cycle |
| irq_o | output | 3 | Per-channel completion pulse |

## Verification
The bench builds the block with its defaults: three channels, eight request lines, 16-bit words and addresses, and a burst run of four. At that size it can cover every combination of source and destination direction and step size, every one of the eight request lines, and three different priority orders. The bus is modelled as a read-only pattern function of the address. Each logged write can therefore be checked against an arithmetic prediction of its address and data. The hold output is traced cycle by cycle, so the bench sees burst gaps and unbroken block runs directly.

// File: rtl/tdma_pkg.sv
package tdma_pkg;
  localparam int unsigned TRIG_W = 3;

  typedef enum logic [1:0] {
    KIND_SINGLE = 2'd0,
    KIND_BLOCK  = 2'd1,
    KIND_BURST  = 2'd2,
    KIND_RSVD   = 2'd3
  } kind_e;

  typedef enum logic [1:0] {
    DIR_FIX  = 2'd0,
    DIR_INC  = 2'd1,
    DIR_DEC  = 2'd2,
    DIR_KEEP = 2'd3
  } dir_e;

  typedef struct packed {
    logic [TRIG_W-1:0] trig;
    logic              dst_wide;
    dir_e              dst_dir;
    logic              src_wide;
    dir_e              src_dir;
    logic              rpt;
    kind_e             kind;
    logic              en;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);

  typedef enum logic [1:0] {
    FLD_CTRL = 2'd0,
    FLD_SRC  = 2'd1,
    FLD_DST  = 2'd2,
    FLD_CNT  = 2'd3
  } field_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2,
    ST_GAP  = 2'd3
  } state_e;
endpackage

// File: rtl/tdma_chan.sv
module tdma_chan
  import tdma_pkg::*;
#(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned NUM_REQ = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_REQ-1:0] req_i,
  input  logic              blk_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_fld_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              start_i,
  input  logic              done_i,
  input  logic              busy_i,
  output logic              pend_o,
  output logic [1:0]        kind_o,
  output logic [ADDR_W-1:0] src_o,
  output logic [ADDR_W-1:0] dst_o,
  output logic              last_o,
  output logic              irq_o
);
  localparam int unsigned SEL_W = $clog2(NUM_REQ);

  ctrl_t              ctrl_q;
  logic [ADDR_W-1:0]  src_q, dst_q, src_sh_q, dst_sh_q;
  logic [CNT_W-1:0]   cnt_q, cnt_sh_q;
  logic [NUM_REQ-1:0] req_q;
  logic               pend_q, irq_q;

  logic wr_ctrl, wr_src, wr_dst, wr_cnt;
  logic [SEL_W-1:0] sel;
  logic fire, trig_ok, last, finish;

  assign wr_ctrl = wr_en_i && (wr_fld_i == FLD_CTRL);
  assign wr_src  = wr_en_i && (wr_fld_i == FLD_SRC);
  assign wr_dst  = wr_en_i && (wr_fld_i == FLD_DST);
  assign wr_cnt  = wr_en_i && (wr_fld_i == FLD_CNT);

  assign sel     = ctrl_q.trig[SEL_W-1:0];
  assign fire    = req_i[sel] & ~req_q[sel];
  assign trig_ok = fire && ctrl_q.en && !blk_i && (cnt_q != '0) && !busy_i;
  assign last    = (cnt_q == CNT_W'(1));
  assign finish  = done_i && last;

  function automatic logic [ADDR_W-1:0] step(input logic [ADDR_W-1:0] a,
                                             input dir_e d, input logic w);
    logic [ADDR_W-1:0] inc;
    inc = w ? ADDR_W'(2) : ADDR_W'(1);
    case (d)
      DIR_INC: return a + inc;
      DIR_DEC: return a - inc;
      default: return a;
    endcase
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      src_q    <= '0;
      dst_q    <= '0;
      src_sh_q <= '0;
      dst_sh_q <= '0;
      cnt_q    <= '0;
      cnt_sh_q <= '0;
      req_q    <= '0;
      pend_q   <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      req_q <= req_i;
      irq_q <= finish;
      if (done_i) begin
        if (last) begin
          if (ctrl_q.rpt) begin
            src_q <= src_sh_q;
            dst_q <= dst_sh_q;
            cnt_q <= cnt_sh_q;
          end else begin
            ctrl_q.en <= 1'b0;
            cnt_q     <= '0;
          end
        end else begin
          src_q <= step(src_q, ctrl_q.src_dir, ctrl_q.src_wide);
          dst_q <= step(dst_q, ctrl_q.dst_dir, ctrl_q.dst_wide);
          cnt_q <= cnt_q - CNT_W'(1);
        end
      end
      // register writes take precedence over engine updates
      if (wr_ctrl) ctrl_q <= ctrl_t'(wr_data_i[CTRL_W-1:0]);
      if (wr_src) begin
        src_q    <= wr_data_i[ADDR_W-1:0];
        src_sh_q <= wr_data_i[ADDR_W-1:0];
      end
      if (wr_dst) begin
        dst_q    <= wr_data_i[ADDR_W-1:0];
        dst_sh_q <= wr_data_i[ADDR_W-1:0];
      end
      if (wr_cnt) begin
        cnt_q    <= wr_data_i[CNT_W-1:0];
        cnt_sh_q <= wr_data_i[CNT_W-1:0];
      end
      if (wr_ctrl || wr_cnt || start_i || (finish && !ctrl_q.rpt)) pend_q <= 1'b0;
      else if (trig_ok)                                             pend_q <= 1'b1;
    end
  end

  assign pend_o = pend_q;
  assign kind_o = ctrl_q.kind;
  assign src_o  = src_q;
  assign dst_o  = dst_q;
  assign last_o = last;
  assign irq_o  = irq_q;

  AST_TRIG_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_q) |-> !$past(blk_i)); // R3
  AST_START_NONEMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> (cnt_q != '0)); // R8
  AST_SELF_DISABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ctrl_q.en) |-> ($past(done_i) || $past(wr_ctrl))); // R7
  AST_IRQ_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> $past(done_i)); // R11
endmodule

// File: rtl/tdma_arb.sv
module tdma_arb #(
  parameter int unsigned NUM_CH = 3,
  parameter int unsigned CH_W   = 2
) (
  input  logic [NUM_CH-1:0]           pend_i,
  input  logic [NUM_CH-1:0][CH_W-1:0] prio_i,
  output logic [NUM_CH-1:0]           grant_o
);
  always_comb begin
    logic found;
    found   = 1'b0;
    grant_o = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (!found && (int'(prio_i[i]) < NUM_CH) && pend_i[prio_i[i]]) begin
        grant_o[prio_i[i]] = 1'b1;
        found              = 1'b1;
      end
    end
  end
endmodule

// File: rtl/tdma_engine.sv
module tdma_engine
  import tdma_pkg::*;
#(
  parameter int unsigned NUM_CH    = 3,
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned BURST_LEN = 4,
  localparam int unsigned CH_W     = $clog2(NUM_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] grant_i,
  input  logic [1:0]        act_kind_i,
  input  logic              act_last_i,
  input  logic [ADDR_W-1:0] act_src_i,
  input  logic [ADDR_W-1:0] act_dst_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [NUM_CH-1:0] start_o,
  output logic [NUM_CH-1:0] done_o,
  output logic [NUM_CH-1:0] busy_o,
  output logic [CH_W-1:0]   act_o,
  output logic              hold_o,
  output logic              re_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o
);
  localparam int unsigned BEAT_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;

  state_e            state_q, state_d;
  logic [CH_W-1:0]   act_q, gidx;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic [DATA_W-1:0] data_q;
  logic [NUM_CH-1:0] act_oh;

  always_comb begin
    gidx = '0;
    for (int i = 0; i < NUM_CH; i++) if (grant_i[i]) gidx = CH_W'(i);
  end

  assign act_oh = NUM_CH'(1) << act_q;

  always_comb begin
    state_d = state_q;
    beat_d  = beat_q;
    case (state_q)
      ST_IDLE: if (|grant_i) begin
        state_d = ST_RD;
        beat_d  = '0;
      end
      ST_RD: state_d = ST_WR;
      ST_WR: begin
        if (act_last_i) state_d = ST_IDLE;
        else if (act_kind_i == KIND_BLOCK) state_d = ST_RD;
        else if (act_kind_i == KIND_BURST) begin
          if (beat_q == BEAT_W'(BURST_LEN - 1)) begin
            state_d = ST_GAP;
            beat_d  = '0;
          end else begin
            state_d = ST_RD;
            beat_d  = beat_q + BEAT_W'(1);
          end
        end else state_d = ST_IDLE;
      end
      default: state_d = ST_RD;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      act_q   <= '0;
      beat_q  <= '0;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      beat_q  <= beat_d;
      if (state_q == ST_IDLE && |grant_i) act_q <= gidx;
      if (state_q == ST_RD) data_q <= rdata_i;
    end
  end

  assign start_o = (state_q == ST_IDLE) ? grant_i : '0;
  assign done_o  = (state_q == ST_WR) ? act_oh : '0;
  assign busy_o  = (state_q != ST_IDLE) ? act_oh : '0;
  assign act_o   = act_q;
  assign re_o    = (state_q == ST_RD);
  assign we_o    = (state_q == ST_WR);
  assign hold_o  = re_o || we_o;
  assign addr_o  = re_o ? act_src_i : act_dst_i;
  assign wdata_o = data_q;

  AST_GAP_AFTER_BURST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_GAP) |-> ($past(state_q) == ST_WR && act_kind_i == KIND_BURST)); // R10
  AST_GAP_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_GAP) |=> re_o); // R10
endmodule

// File: rtl/tdma_ctrl.sv
module tdma_ctrl
  import tdma_pkg::*;
#(
  parameter int unsigned NUM_CH    = 3,
  parameter int unsigned NUM_REQ   = 8,
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned BURST_LEN = 4,
  localparam int unsigned CH_W     = $clog2(NUM_CH),
  localparam int unsigned CH_AW    = $clog2(NUM_CH + 1),
  localparam int unsigned REG_AW   = CH_AW + 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_we_i,
  input  logic [REG_AW-1:0]  reg_addr_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  input  logic [NUM_REQ-1:0] dma_req_i,
  input  logic               trig_block_i,
  output logic               cpu_hold_o,
  output logic               mem_re_o,
  output logic               mem_we_o,
  output logic [ADDR_W-1:0]  mem_addr_o,
  output logic [DATA_W-1:0]  mem_wdata_o,
  input  logic [DATA_W-1:0]  mem_rdata_i,
  output logic [NUM_CH-1:0]  irq_o
);
  logic [NUM_CH-1:0][CH_W-1:0] prio_q;
  logic [NUM_CH-1:0] pend, grant, start, done, busy;
  logic [ADDR_W-1:0] src_a [NUM_CH];
  logic [ADDR_W-1:0] dst_a [NUM_CH];
  logic [1:0]        kind_a [NUM_CH];
  logic [NUM_CH-1:0] last_a;
  logic [CH_W-1:0]   act;
  logic [CH_AW-1:0]  reg_ch;
  logic              wr_prio;

  assign reg_ch  = reg_addr_i[REG_AW-1:2];
  assign wr_prio = reg_we_i && (reg_ch == CH_AW'(NUM_CH)) && (reg_addr_i[1:0] == 2'd0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_CH; i++) prio_q[i] <= CH_W'(i);
    end else if (wr_prio) begin
      prio_q <= reg_wdata_i[NUM_CH*CH_W-1:0];
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    tdma_chan #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .CNT_W  (CNT_W),
      .NUM_REQ(NUM_REQ)
    ) u_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .req_i    (dma_req_i),
      .blk_i    (trig_block_i),
      .wr_en_i  (reg_we_i && (reg_ch == CH_AW'(c))),
      .wr_fld_i (reg_addr_i[1:0]),
      .wr_data_i(reg_wdata_i),
      .start_i  (start[c]),
      .done_i   (done[c]),
      .busy_i   (busy[c]),
      .pend_o   (pend[c]),
      .kind_o   (kind_a[c]),
      .src_o    (src_a[c]),
      .dst_o    (dst_a[c]),
      .last_o   (last_a[c]),
      .irq_o    (irq_o[c])
    );
  end

  tdma_arb #(
    .NUM_CH(NUM_CH),
    .CH_W  (CH_W)
  ) u_arb (
    .pend_i (pend),
    .prio_i (prio_q),
    .grant_o(grant)
  );

  tdma_engine #(
    .NUM_CH   (NUM_CH),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .BURST_LEN(BURST_LEN)
  ) u_engine (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .grant_i   (grant),
    .act_kind_i(kind_a[act]),
    .act_last_i(last_a[act]),
    .act_src_i (src_a[act]),
    .act_dst_i (dst_a[act]),
    .rdata_i   (mem_rdata_i),
    .start_o   (start),
    .done_o    (done),
    .busy_o    (busy),
    .act_o     (act),
    .hold_o    (cpu_hold_o),
    .re_o      (mem_re_o),
    .we_o      (mem_we_o),
    .addr_o    (mem_addr_o),
    .wdata_o   (mem_wdata_o)
  );

  AST_READ_THEN_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o |=> mem_we_o); // R5
  AST_HOLD_ON_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_re_o || mem_we_o) |-> cpu_hold_o); // R5
  AST_RW_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_re_o && mem_we_o)); // R5
  AST_GRANT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant)); // R4
  AST_GRANT_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant & ~pend) == '0); // R4
  AST_IRQ_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(irq_o)); // R11
endmodule

// File: tb/tdma_ctrl_tb_top.sv
module tdma_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG = 50000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [7:0]  req = '0;
  logic        blk = 1'b0;
  logic        hold, mem_re, mem_we;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic [2:0]  irq;

  int nchk = 0, nerr = 0;
  bit finished = 0;

  logic [15:0] wlog_a [256];
  logic [15:0] wlog_d [256];
  logic [15:0] rlog   [256];
  int wn, rn, hold_n, first_c, last_c, cyc, gn;
  int gap_at [8];
  int irq_cnt [3];
  bit seen, prev_hold;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] pat(input logic [15:0] a);
    return {a[7:0], a[15:8]} ^ 16'h3C5A;
  endfunction
  assign mem_rdata = pat(mem_addr);

  tdma_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .dma_req_i(req), .trig_block_i(blk),
    .cpu_hold_o(hold), .mem_re_o(mem_re), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .irq_o(irq)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_re && rn < 256) begin rlog[rn] = mem_addr; rn++; end
      if (mem_we && wn < 256) begin wlog_a[wn] = mem_addr; wlog_d[wn] = mem_wdata; wn++; end
      for (int c = 0; c < 3; c++) if (irq[c]) irq_cnt[c]++;
      if (hold) begin
        if (!seen) first_c = cyc;
        seen = 1; last_c = cyc; hold_n++;
      end
      if (!hold && prev_hold && gn < 8) begin gap_at[gn] = wn; gn++; end
      prev_hold = hold;
      cyc++;
    end
  end

  task automatic clr();
    wn = 0; rn = 0; hold_n = 0; first_c = 0; last_c = -1; gn = 0; seen = 0;
    for (int c = 0; c < 3; c++) irq_cnt[c] = 0;
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wr_reg(input int ch, input int fld, input int data);
    tick(1);
    reg_we = 1'b1; reg_addr = 4'(ch * 4 + fld); reg_wdata = 16'(data);
    tick(1);
    reg_we = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] lines);
    tick(1); req = lines;
    tick(1); req = '0;
  endtask

  function automatic logic [15:0] mk(input int en, input int kind, input int rpt,
      input int sd, input int sw, input int dd, input int dw, input int trig);
    return 16'(en | (kind << 1) | (rpt << 3) | (sd << 4) | (sw << 6) |
               (dd << 7) | (dw << 9) | (trig << 10));
  endfunction

  function automatic int dlt(input int dir, input int wide);
    int s;
    s = wide ? 2 : 1;
    return (dir == 1) ? s : (dir == 2) ? -s : 0;
  endfunction

  task automatic prog(input int ch, input int src, input int dst, input int cnt, input logic [15:0] ctrl);
    wr_reg(ch, 1, src); wr_reg(ch, 2, dst); wr_reg(ch, 3, cnt); wr_reg(ch, 0, ctrl);
  endtask

  task automatic disarm_all();
    for (int c = 0; c < 3; c++) wr_reg(c, 0, 0);
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!finished) begin
      nerr++; nchk++;
      $display("FAIL watchdog actual=%0d expected=%0d", WDOG, 0);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    clr(); cyc = 0; prev_hold = 0;
    tick(3); rst_n = 1'b1; tick(1);
    // R1 reset state
    check(!hold && !mem_re && !mem_we && irq == 3'b000, "R1 outputs after reset",
          {hold, mem_re, mem_we, irq}, 0);
    clr(); pulse(8'hFF); tick(10);
    check(wn == 0, "R1 disarmed after reset", wn, 0);

    // R6/R9/R5/R11: sweep of address stepping in block mode
    for (int sd = 0; sd < 3; sd++)
      for (int sw = 0; sw < 2; sw++)
        for (int dd = 0; dd < 3; dd++)
          for (int dw = 0; dw < 2; dw++) begin
            clr();
            prog(0, 16'h0100, 16'h0300, 3, mk(1, 1, 0, sd, sw, dd, dw, 0));
            pulse(8'h01); tick(20);
            check(wn == 3 && rn == 3 && irq_cnt[0] == 1 && hold_n == 6 && gn == 1,
                  "R9 R11 block count/irq/hold", wn * 256 + hold_n, 3 * 256 + 6);
            for (int k = 0; k < 3; k++) begin
              logic [15:0] es, ed;
              es = 16'(16'h0100 + k * dlt(sd, sw));
              ed = 16'(16'h0300 + k * dlt(dd, dw));
              check(rlog[k] == es && wlog_a[k] == ed && wlog_d[k] == pat(es),
                    "R6 R5 stepped address/data", {wlog_a[k], wlog_d[k]}, {ed, pat(es)});
            end
          end

    // R7/R11 single mode
    clr();
    prog(1, 16'h0040, 16'h0080, 3, mk(1, 0, 0, 1, 0, 1, 0, 3));
    for (int p = 1; p <= 4; p++) begin
      pulse(8'h08); tick(8);
      check(wn == ((p < 3) ? p : 3), "R7 one word per request", wn, (p < 3) ? p : 3);
      check(irq_cnt[1] == ((p >= 3) ? 1 : 0), "R11 single irq at end", irq_cnt[1], (p >= 3) ? 1 : 0);
    end
    check(wlog_a[2] == 16'h0082 && wlog_d[2] == pat(16'h0042), "R7 third single word",
          wlog_a[2], 16'h0082);

    // R8 zero count
    clr();
    prog(2, 16'h0010, 16'h0020, 0, mk(1, 1, 0, 1, 0, 1, 0, 2));
    pulse(8'h04); tick(10);
    check(wn == 0 && irq_cnt[2] == 0, "R8 zero count moves nothing", wn, 0);

    // R9 block of five, then disarmed
    clr();
    prog(0, 16'h0200, 16'h0400, 5, mk(1, 1, 0, 1, 0, 1, 0, 1));
    pulse(8'h02); tick(20);
    check(hold_n == 10 && (last_c - first_c + 1) == 10, "R9 unbroken hold",
          last_c - first_c + 1, 10);
    check(wn == 5 && irq_cnt[0] == 1, "R9 block length", wn, 5);
    clr(); pulse(8'h02); tick(10);
    check(wn == 0, "R9 disarmed after block", wn, 0);

    // R10 burst of ten
    clr();
    prog(0, 16'h0200, 16'h0400, 10, mk(1, 2, 0, 1, 0, 1, 0, 1));
    pulse(8'h02); tick(40);
    check(wn == 10 && irq_cnt[0] == 1, "R10 burst length", wn, 10);
    check(hold_n == 20 && (last_c - first_c + 1) == 22, "R10 two one-cycle gaps",
          last_c - first_c + 1, 22);
    check(gn == 3 && gap_at[0] == 4 && gap_at[1] == 8 && gap_at[2] == 10,
          "R10 gap after every fourth", gap_at[0] * 16 + gap_at[1], 4 * 16 + 8);

    // R12 repeat
    clr();
    prog(1, 16'h0200, 16'h0400, 2, mk(1, 1, 1, 1, 0, 1, 1, 5));
    pulse(8'h20); tick(12);
    pulse(8'h20); tick(12);
    check(wn == 4 && irq_cnt[1] == 2, "R12 repeated block reruns", wn, 4);
    check(wlog_a[2] == 16'h0400 && wlog_a[3] == 16'h0402 && wlog_d[3] == pat(16'h0201),
          "R12 reload of addresses", wlog_a[2], 16'h0400);

    // R3 trigger veto
    disarm_all(); clr();
    prog(2, 16'h0030, 16'h0050, 2, mk(1, 0, 0, 0, 0, 0, 0, 6));
    blk = 1'b1; pulse(8'h40); tick(6);
    check(wn == 0, "R3 edge under veto", wn, 0);
    blk = 1'b0; tick(8);
    check(wn == 0, "R3 no late start", wn, 0);
    pulse(8'h40); tick(8);
    check(wn == 1, "R3 edge after veto", wn, 1);

    // R2 request select sweep
    disarm_all();
    for (int k = 0; k < 8; k++) begin
      clr();
      prog(0, 16'h0060, 16'h0070, 1, mk(1, 0, 1, 0, 0, 0, 0, k));
      pulse(~(8'(1) << k)); tick(8);
      check(wn == 0, "R2 other lines ignored", wn, 0);
      pulse(8'(1) << k); tick(8);
      check(wn == 1 && wlog_a[0] == 16'h0070, "R2 selected line fires", wn, 1);
    end

    // R4 priority orders
    disarm_all();
    for (int o = 0; o < 3; o++) begin
      int ord [3];
      if (o == 0) begin ord = '{0, 1, 2}; end
      else if (o == 1) begin ord = '{2, 0, 1}; wr_reg(3, 0, 2 | (0 << 2) | (1 << 4)); end
      else begin ord = '{1, 2, 0}; wr_reg(3, 0, 1 | (2 << 2) | (0 << 4)); end
      clr();
      for (int c = 0; c < 3; c++)
        prog(c, 16'h0010 * (c + 1), 16'h0500 + 16'h0100 * c, 1, mk(1, 0, 0, 0, 0, 0, 0, 7));
      pulse(8'h80); tick(20);
      check(wn == 3, "R4 all served", wn, 3);
      for (int s = 0; s < 3; s++)
        check(wlog_a[s] == 16'(16'h0500 + 16'h0100 * ord[s]), "R4 service order",
              wlog_a[s], 16'h0500 + 16'h0100 * ord[s]);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule